// File: doc/BRIEF.md
# Processor Power Mode Controller

This block decides which clock domains of a small processor core are allowed to toggle. Software writes a three-bit mode code. Two of the codes are run modes. Full-on keeps every clock running. Dynamic gates an execution unit's clock for each cycle that the unit is idle and has nothing dispatched to it. The remaining three codes arm a static low-power state: doze, nap or sleep. Each one stops a larger set of domains than the one before it.

An armed static state does not take effect on its own. A later sleep request puts the controller in a pending state. The controller then waits until every execution unit is idle and nothing is being dispatched, and only then drops the clock enables. A wake event, such as an interrupt or a reset request from the wake logic, brings back every enable at the next clock edge. It also restores the run mode that was in force before the static state was entered, and disarms the static target. The wake logic itself has no enable and always runs.

The status outputs give the effective mode code, a flag for a static state in force, and a flag for a request that is waiting for the units to drain.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is active, and right after it, every clock enable is 1, stat_mode reads 000, and stat_static and stat_pending are 0.
- R2: A write of 000 selects full-on and a write of 001 selects dynamic. Codes 101, 110 and 111 act exactly like 000. When no static state is in force, stat_mode shows the selected run mode from the edge that samples the write.
- R3: In full-on mode, unit_ce, cache_ce, mmu_ce and core_ce are all 1, whatever unit_idle and unit_dispatch hold.
- R4: In dynamic mode, unit_ce[i] equals (!unit_idle[i] | unit_dispatch[i]) in the same cycle, combinationally. This means a dispatch re-enables its unit without losing a cycle. cache_ce, mmu_ce and core_ce stay 1.
- R5: Codes 010 (doze), 011 (nap) and 100 (sleep) only arm a static target and leave stat_mode unchanged. A sleep_req sampled while a target is armed sets stat_pending at that edge. A sleep_req with nothing armed is ignored. Writing a run-mode code while pending cancels the request.
- R6: The static state is entered at the edge that samples pending with all unit_idle bits at 1, no unit_dispatch bit at 1, and no wake_evt. stat_static then becomes 1 and stat_pending becomes 0. If any unit is busy or receiving a dispatch, the request stays pending.
- R7: In doze (stat_mode 010), every unit_ce is 0, while cache_ce, mmu_ce and core_ce are 1.
- R8: In nap (stat_mode 011), every unit_ce is 0 and cache_ce and mmu_ce are 0, while core_ce is 1.
- R9: In sleep (stat_mode 100), every clock enable output is 0. The depth order is doze < nap < sleep.
- R10: While a static state is in force, mode writes, sleep_req, unit_idle and unit_dispatch have no effect on any output until a wake event arrives.
- R11: At the edge that samples wake_evt during a static state, stat_static clears, every enable is set back according to the run mode held before entry, stat_mode shows that run mode, and the target is disarmed, so a later sleep_req is ignored. A wake_evt while pending cancels the request and disarms the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the wake logic, never gated |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Strobe for a mode-code write |
| mode_code | input | 3 | Mode code written on mode_wr |
| sleep_req | input | 1 | Software request to enter the armed static state |
| wake_evt | input | 1 | Interrupt or reset wake event |
| unit_idle | input | N_UNITS | Per execution unit: 1 when idle |
| unit_dispatch | input | N_UNITS | Per execution unit: 1 when an operation is dispatched this cycle |
| unit_ce | output | N_UNITS | Clock enable per execution unit |
| cache_ce | output | 1 | Clock enable of the cache domain |
| mmu_ce | output | 1 | Clock enable of the translation domain |
| core_ce | output | 1 | Clock enable of the remaining core domain |
| stat_mode | output | 3 | Effective mode code |
| stat_static | output | 1 | A static low-power state is in force |
| stat_pending | output | 1 | A sleep request is waiting for the units to drain |

## Verification
A wrong sequencer state shows up at the next clock edge. A state stuck in low power leaves enables at 0 after a wake event. A missed entry leaves stat_pending set while all units are idle, and a spurious entry drops enables without a request. A wrong static target or a wrong saved run mode shows up at once as a wrong stat_mode code, and as the wrong set of domains being gated in the same cycle. A wrong dynamic gating term appears combinationally on unit_ce for the affected idle and dispatch pattern, so the sweep of every pattern catches it in that cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PM_FULL  = 3'd0,
    PM_DYN   = 3'd1,
    PM_DOZE  = 3'd2,
    PM_NAP   = 3'd3,
    PM_SLEEP = 3'd4
  } pm_mode_e;

  typedef enum logic [1:0] {
    SQ_RUN  = 2'd0,
    SQ_PEND = 2'd1,
    SQ_LOW  = 2'd2
  } sq_state_e;

  // Codes outside the defined set behave as full-on.
  function automatic pm_mode_e pm_normalize(input logic [2:0] code);
    pm_mode_e m;
    case (code)
      3'd1:    m = PM_DYN;
      3'd2:    m = PM_DOZE;
      3'd3:    m = PM_NAP;
      3'd4:    m = PM_SLEEP;
      default: m = PM_FULL;
    endcase
    return m;
  endfunction

  function automatic logic pm_is_static(input pm_mode_e m);
    return (m == PM_DOZE) || (m == PM_NAP) || (m == PM_SLEEP);
  endfunction

  // Gating depth: 0 none, 1 units, 2 units+cache+mmu, 3 everything.
  function automatic logic [1:0] pm_depth(input pm_mode_e m);
    logic [1:0] d;
    case (m)
      PM_DOZE:  d = 2'd1;
      PM_NAP:   d = 2'd2;
      PM_SLEEP: d = 2'd3;
      default:  d = 2'd0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pmc_mode_reg.sv
module pmc_mode_reg
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic [2:0] wr_code,
  input  logic     lock,
  input  logic     disarm,
  output pm_mode_e run_mode,
  output pm_mode_e target,
  output logic     armed
);

  pm_mode_e wr_mode;
  assign wr_mode = pm_normalize(wr_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_mode <= PM_FULL;
      target   <= PM_DOZE;
      armed    <= 1'b0;
    end else if (disarm) begin
      armed <= 1'b0;
    end else if (wr_en && !lock) begin
      if (pm_is_static(wr_mode)) begin
        target <= wr_mode;
        armed  <= 1'b1;
      end else begin
        run_mode <= wr_mode;
        armed    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_evt,
  input  logic armed,
  input  logic all_quiet,
  output logic pending,
  output logic in_static,
  output logic evt_enter,
  output logic evt_wake
);

  sq_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      SQ_RUN:  if (sleep_req && armed && !wake_evt) st_nx = SQ_PEND;
      SQ_PEND: begin
        if (wake_evt || !armed) st_nx = SQ_RUN;
        else if (all_quiet)     st_nx = SQ_LOW;
      end
      SQ_LOW:  if (wake_evt) st_nx = SQ_RUN;
      default: st_nx = SQ_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= SQ_RUN;
    else        st <= st_nx;
  end

  assign pending   = (st == SQ_PEND);
  assign in_static = (st == SQ_LOW);
  assign evt_enter = (st == SQ_PEND) && (st_nx == SQ_LOW);
  assign evt_wake  = (st == SQ_LOW) && wake_evt;

endmodule

// File: rtl/pmc_gate.sv
module pmc_gate
  import pmc_pkg::*;
#(
  parameter int N_UNITS = 4
)(
  input  logic               in_static,
  input  pm_mode_e           static_kind,
  input  pm_mode_e           run_mode,
  input  logic [N_UNITS-1:0] unit_idle,
  input  logic [N_UNITS-1:0] unit_dispatch,
  output logic [N_UNITS-1:0] unit_ce,
  output logic               cache_ce,
  output logic               mmu_ce,
  output logic               core_ce
);

  logic [1:0] depth;
  logic       dyn_on;

  assign depth  = in_static ? pm_depth(static_kind) : 2'd0;
  assign dyn_on = !in_static && (run_mode == PM_DYN);

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    logic need_clk;
    assign need_clk   = !unit_idle[i] || unit_dispatch[i];
    assign unit_ce[i] = (depth != 2'd0) ? 1'b0 : (dyn_on ? need_clk : 1'b1);
  end

  assign cache_ce = (depth < 2'd2);
  assign mmu_ce   = (depth < 2'd2);
  assign core_ce  = (depth < 2'd3);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int N_UNITS = 4
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr,
  input  logic [2:0]         mode_code,
  input  logic               sleep_req,
  input  logic               wake_evt,
  input  logic [N_UNITS-1:0] unit_idle,
  input  logic [N_UNITS-1:0] unit_dispatch,
  output logic [N_UNITS-1:0] unit_ce,
  output logic               cache_ce,
  output logic               mmu_ce,
  output logic               core_ce,
  output logic [2:0]         stat_mode,
  output logic               stat_static,
  output logic               stat_pending
);

  pm_mode_e run_mode, target;
  logic     armed, all_quiet, in_static, pending;
  logic     evt_enter, evt_wake;

  assign all_quiet = (&unit_idle) && !(|unit_dispatch);

  pmc_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (mode_wr),
    .wr_code  (mode_code),
    .lock     (in_static),
    .disarm   (wake_evt),
    .run_mode (run_mode),
    .target   (target),
    .armed    (armed)
  );

  pmc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .wake_evt  (wake_evt),
    .armed     (armed),
    .all_quiet (all_quiet),
    .pending   (pending),
    .in_static (in_static),
    .evt_enter (evt_enter),
    .evt_wake  (evt_wake)
  );

  pmc_gate #(.N_UNITS(N_UNITS)) u_gate (
    .in_static     (in_static),
    .static_kind   (target),
    .run_mode      (run_mode),
    .unit_idle     (unit_idle),
    .unit_dispatch (unit_dispatch),
    .unit_ce       (unit_ce),
    .cache_ce      (cache_ce),
    .mmu_ce        (mmu_ce),
    .core_ce       (core_ce)
  );

  assign stat_mode    = in_static ? target : run_mode;
  assign stat_static  = in_static;
  assign stat_pending = pending;

endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
  parameter int N_UNITS = 4
)(
  input logic               clk,
  input logic               rst_n,
  input logic               sleep_req,
  input logic               wake_evt,
  input logic [N_UNITS-1:0] unit_idle,
  input logic [N_UNITS-1:0] unit_dispatch,
  input logic [N_UNITS-1:0] unit_ce,
  input logic               cache_ce,
  input logic               mmu_ce,
  input logic               core_ce,
  input logic [2:0]         stat_mode,
  input logic               stat_static,
  input logic               stat_pending,
  input logic               evt_enter,
  input logic               evt_wake
);

  p_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_static && stat_mode == 3'd0) |-> (&unit_ce && cache_ce && mmu_ce && core_ce));

  p_dyn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_static && stat_mode == 3'd1) |-> (unit_ce == (~unit_idle | unit_dispatch)));

  p_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_pending) |-> $past(sleep_req));

  p_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_pending && &unit_idle && !(|unit_dispatch) && !wake_evt && evt_enter)
      |=> (stat_static && !stat_pending));

  p_doze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_static && stat_mode == 3'd2) |-> (unit_ce == '0 && cache_ce && mmu_ce && core_ce));

  p_nap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_static && stat_mode == 3'd3) |-> (unit_ce == '0 && !cache_ce && !mmu_ce && core_ce));

  p_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_static && stat_mode == 3'd4) |-> (unit_ce == '0 && !cache_ce && !mmu_ce && !core_ce));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_static && !wake_evt) |=> (stat_static && $stable(stat_mode)));

  p_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wake |=> (!stat_static && cache_ce && mmu_ce && core_ce));

endmodule

bind pwr_mode_ctrl pmc_chk #(.N_UNITS(N_UNITS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sleep_req     (sleep_req),
  .wake_evt      (wake_evt),
  .unit_idle     (unit_idle),
  .unit_dispatch (unit_dispatch),
  .unit_ce       (unit_ce),
  .cache_ce      (cache_ce),
  .mmu_ce        (mmu_ce),
  .core_ce       (core_ce),
  .stat_mode     (stat_mode),
  .stat_static   (stat_static),
  .stat_pending  (stat_pending),
  .evt_enter     (evt_enter),
  .evt_wake      (evt_wake)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;

  localparam int N = 4;
  localparam int W = N + 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_wr;
  logic [2:0]   mode_code;
  logic         sleep_req;
  logic         wake_evt;
  logic [N-1:0] unit_idle;
  logic [N-1:0] unit_dispatch;
  logic [N-1:0] unit_ce;
  logic         cache_ce, mmu_ce, core_ce;
  logic [2:0]   stat_mode;
  logic         stat_static, stat_pending;

  int total = 0;
  int bad   = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.N_UNITS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
    .sleep_req(sleep_req), .wake_evt(wake_evt), .unit_idle(unit_idle),
    .unit_dispatch(unit_dispatch), .unit_ce(unit_ce), .cache_ce(cache_ce),
    .mmu_ce(mmu_ce), .core_ce(core_ce), .stat_mode(stat_mode),
    .stat_static(stat_static), .stat_pending(stat_pending)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // Expected {core,mmu,cache,units}: lvl counts how many domain groups are stopped.
  function automatic logic [W-1:0] exp_en(input int lvl, input int run,
                                          input logic [N-1:0] idl, input logic [N-1:0] dsp);
    logic [W-1:0] e;
    for (int i = 0; i < N; i++) begin
      if (lvl > 0)       e[i] = 1'b0;
      else if (run == 1) e[i] = (idl[i] == 1'b0) || (dsp[i] == 1'b1);
      else               e[i] = 1'b1;
    end
    e[N]   = (lvl < 2);
    e[N+1] = (lvl < 2);
    e[N+2] = (lvl < 3);
    return e;
  endfunction

  function automatic logic [W-1:0] got_en();
    return {core_ce, mmu_ce, cache_ce, unit_ce};
  endfunction

  task automatic write_mode(input logic [2:0] c);
    mode_wr = 1'b1; mode_code = c;
    tick();
    mode_wr = 1'b0;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_wr = 1'b0; mode_code = 3'd0; sleep_req = 1'b0;
    wake_evt = 1'b0; unit_idle = '1; unit_dispatch = '0;
    repeat (3) tick();
    // R1 reset state
    chk("R1 enables in reset", got_en(), exp_en(0, 0, '1, '0));
    chk("R1 mode in reset", stat_mode, 0);
    chk("R1 flags in reset", {stat_static, stat_pending}, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 enables after reset", got_en(), exp_en(0, 0, '1, '0));
    chk("R1 flags after reset", {stat_static, stat_pending}, 0);

    // R3 full-on ignores idle pattern
    for (int v = 0; v < 16; v++) begin
      unit_idle = v[N-1:0]; unit_dispatch = 4'(15 - v);
      #1 chk("R3 full-on enables", got_en(), exp_en(0, 0, unit_idle, unit_dispatch));
    end

    // R2 run-mode codes and out-of-range codes
    write_mode(3'd1);
    chk("R2 code 001 dynamic", stat_mode, 1);
    for (int c = 5; c < 8; c++) begin
      write_mode(3'd1);
      write_mode(c[2:0]);
      chk("R2 invalid code acts as full-on", stat_mode, 0);
    end
    write_mode(3'd0);
    chk("R2 code 000 full-on", stat_mode, 0);

    // R4 dynamic mode: every idle/dispatch pattern
    write_mode(3'd1);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        unit_idle = a[N-1:0]; unit_dispatch = b[N-1:0];
        #1 chk("R4 dynamic gating", got_en(), exp_en(0, 1, unit_idle, unit_dispatch));
      end
    end
    unit_idle = '1; unit_dispatch = '0;

    // R5 request with nothing armed is ignored
    pulse_sleep();
    chk("R5 unarmed request ignored", {stat_static, stat_pending}, 0);

    // Main sweep: each run mode and each static kind
    for (int run = 0; run < 2; run++) begin
      for (int kind = 2; kind < 5; kind++) begin
        write_mode(run[2:0]);
        write_mode(kind[2:0]);
        chk("R5 arming leaves stat_mode", stat_mode, run);
        unit_idle = 4'b0111; unit_dispatch = '0;
        pulse_sleep();
        chk("R5 pending after request", {stat_static, stat_pending}, 2'b01);
        tick(); tick();
        chk("R6 busy unit holds pending", {stat_static, stat_pending}, 2'b01);
        chk("R6 run gating while pending", got_en(), exp_en(0, run, unit_idle, unit_dispatch));
        unit_idle = '1; unit_dispatch = 4'b0001;
        tick();
        chk("R6 dispatch blocks entry", {stat_static, stat_pending}, 2'b01);
        unit_dispatch = '0;
        tick();
        chk("R6 entered static", {stat_static, stat_pending}, 2'b10);
        chk("R7 R8 R9 static mode code", stat_mode, kind);
        chk("R7 R8 R9 static enables", got_en(), exp_en(kind - 1, run, unit_idle, unit_dispatch));
        // R10 inputs ignored while static
        mode_wr = 1'b1; mode_code = 3'd1; sleep_req = 1'b1;
        unit_idle = '0; unit_dispatch = '1;
        tick();
        mode_wr = 1'b0; sleep_req = 1'b0;
        chk("R10 still static", {stat_static, stat_pending}, 2'b10);
        chk("R10 mode unchanged", stat_mode, kind);
        chk("R10 enables unchanged", got_en(), exp_en(kind - 1, run, unit_idle, unit_dispatch));
        unit_idle = 4'b1010; unit_dispatch = 4'b0100;
        // R11 wake restores run mode
        wake_evt = 1'b1;
        tick();
        wake_evt = 1'b0;
        chk("R11 static cleared", {stat_static, stat_pending}, 0);
        chk("R11 run mode restored", stat_mode, run);
        chk("R11 enables restored", got_en(), exp_en(0, run, unit_idle, unit_dispatch));
        unit_idle = '1; unit_dispatch = '0;
        pulse_sleep();
        tick();
        chk("R11 target disarmed", {stat_static, stat_pending}, 0);
      end
    end

    // R11 wake while pending cancels
    write_mode(3'd3);
    unit_idle = 4'b1110;
    pulse_sleep();
    chk("R11 pending before wake", stat_pending, 1);
    wake_evt = 1'b1;
    tick();
    wake_evt = 1'b0;
    unit_idle = '1;
    tick(); tick();
    chk("R11 wake cancels pending", {stat_static, stat_pending}, 0);

    // R5 run-mode write while pending cancels
    write_mode(3'd2);
    unit_idle = 4'b0011;
    pulse_sleep();
    chk("R5 pending before cancel", stat_pending, 1);
    write_mode(3'd1);
    unit_idle = '1;
    tick(); tick();
    chk("R5 run write cancels request", {stat_static, stat_pending}, 0);
    chk("R5 dynamic mode after cancel", stat_mode, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule